// File: doc/BRIEF.md
# Snoop-Side Injection Window Table

This block sits beside a bus-snooping cache controller and decides, for every data transaction seen on the shared bus, whether the local cache should capture that line even though it never asked for it. Software describes the address ranges it expects to consume. It issues an open-low command that carries the first line of a range, then an open-high command that carries the last line. The range then becomes a live window. A close command that names the low line retires every window that starts there.

Each window has a capture mode. A window in read-response mode captures the data of read-miss replies that other processors triggered. A window in update mode captures the data that a producer pushes with an update or store-update transaction. All live windows are compared against the snooped line address in one cycle. When a window matches, the block pulses a capture strobe one cycle later so that the controller installs the line in the Shared state. The capture is dropped when the victim line holds owned data. Addresses at every port are line addresses, so the byte offset inside a line plays no part in matching.

Top module: `inj_window_table`

## Requirements
- R1: After reset no window is live, `tbl_full` is low, and `inj_fire` and `inj_drop` are low. A snoop then causes no capture.
- R2: Command `cmd_op` = 2'b01 (open-low) followed by 2'b10 (open-high) creates a live window in the lowest-numbered free slot. A foreign snoop whose line lies within [low, high], bounds included, and whose victim is replaceable makes `inj_fire` high for exactly the cycle after the snoop, with `inj_line` equal to the snooped line. Lines just outside either bound do not capture.
- R3: Matching uses line addresses only. Every address port carries the address with the line-offset bits already removed.
- R4: A window opened with `cmd_mode` = 0 captures only snoops with `snp_kind` = 0 (read-miss reply). A window opened with `cmd_mode` = 1 captures only `snp_kind` = 1 (update or store-update).
- R5: A snoop with `snp_own` = 1 (this cache's own transaction) never raises `inj_fire` or `inj_drop`.
- R6: `vic_state` encodes 2'b00 Invalid, 2'b01 Shared, 2'b10 Modified and 2'b11 Exclusive. A matching snoop fires only when the victim is Invalid or Shared. Otherwise it raises `inj_drop` for one cycle instead, and `inj_fire` stays low.
- R7: An open-high command with no open-low pending is ignored and creates no window.
- R8: `tbl_full` is high while every slot is live. An open-low command issued while full leaves the table unchanged and leaves nothing pending, so a following open-high is also ignored.
- R9: Close (`cmd_op` = 2'b11) retires every live window whose low line equals `cmd_line` and leaves the others live. A retired slot is free for reuse.
- R10: A snoop that matches several overlapping windows yields a single one-cycle capture. `inj_fire` and `inj_drop` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Window command present this cycle |
| cmd_op | input | 2 | 01 open-low, 10 open-high, 11 close, 00 none |
| cmd_mode | input | 1 | Capture mode latched by open-low: 0 read reply, 1 update |
| cmd_line | input | LINE_W | Line address carried by the command |
| snp_valid | input | 1 | Snooped data transaction present this cycle |
| snp_kind | input | 1 | 0 read-miss reply, 1 update or store-update |
| snp_own | input | 1 | Transaction was issued by this cache |
| snp_line | input | LINE_W | Snooped line address |
| vic_state | input | 2 | Coherence state of the line the capture would replace |
| inj_fire | output | 1 | Install the snooped line as Shared (one cycle after snoop) |
| inj_drop | output | 1 | Window matched but the victim is owned, so capture is abandoned |
| inj_line | output | LINE_W | Line address of the last match |
| tbl_full | output | 1 | All window slots are live |

## Verification
The bench probes the first and last line of a window and the lines just outside it. A design that got these bounds wrong by one would capture a neighbour or miss an edge line. It crosses each window mode with both transaction kinds, its own traffic and owned victims. A design that ignored the mode, the own flag or the victim state would install lines it must not touch, or overwrite dirty data. It fills the table, then tries an open-low and an orphan open-high. A design that let either through would overwrite a live slot or open a window with stale bounds. Overlapping windows sharing one low line are retired by a single close. A design that cleared only the first match would keep capturing afterwards.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOW   = 2'b01,
    OP_HIGH  = 2'b10,
    OP_CLOSE = 2'b11
  } inj_op_e;

  typedef enum logic [1:0] {
    VIC_INV = 2'b00,
    VIC_SHR = 2'b01,
    VIC_MOD = 2'b10,
    VIC_EXC = 2'b11
  } vic_state_e;
endpackage

// File: rtl/inj_alloc.sv
module inj_alloc #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         none_free
);
  // lowest free slot wins: scan downward so the last assignment is the lowest
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign none_free = &busy;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & busy) == '0);
  assert_full_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    none_free |-> (grant == '0));
endmodule

// File: rtl/inj_entry.sv
module inj_entry #(
  parameter int LW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lo,
  input  logic [LW-1:0] wr_hi,
  input  logic          wr_mode,
  input  logic          clr_en,
  input  logic [LW-1:0] clr_line,
  input  logic          snp_kind,
  input  logic [LW-1:0] snp_line,
  output logic          vld,
  output logic          hit
);
  logic          vld_q, vld_d;
  logic [LW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic          mode_q, mode_d;
  logic          close_match;

  assign close_match = clr_en && vld_q && (lo_q == clr_line);

  always_comb begin
    vld_d  = vld_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    mode_d = mode_q;
    if (wr_en) begin
      vld_d  = 1'b1;
      lo_d   = wr_lo;
      hi_d   = wr_hi;
      mode_d = wr_mode;
    end else if (close_match) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      mode_q <= mode_d;
    end
  end

  assign vld = vld_q;
  assign hit = vld_q && (mode_q == snp_kind) &&
               (snp_line >= lo_q) && (snp_line <= hi_q);

  assert_live_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(wr_en));
  assert_close_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en && vld_q && (lo_q == clr_line)) |=> !vld_q);
  assert_no_write_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !vld_q);
endmodule

// File: rtl/inj_window_table.sv
module inj_window_table #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ENTRIES    = 128,
  localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_mode,
  input  logic [LINE_W-1:0] cmd_line,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic              snp_own,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [1:0]        vic_state,
  output logic              inj_fire,
  output logic              inj_drop,
  output logic [LINE_W-1:0] inj_line,
  output logic              tbl_full
);
  import inj_pkg::*;

  // staging of the low bound between open-low and open-high
  logic              pend_q, pend_d;
  logic [LINE_W-1:0] plo_q, plo_d;
  logic              pmode_q, pmode_d;

  logic [ENTRIES-1:0] vld, hit, grant, wr_en;
  logic               none_free;
  logic               is_low, is_high, is_close;

  assign is_low   = cmd_valid && (cmd_op == OP_LOW);
  assign is_high  = cmd_valid && (cmd_op == OP_HIGH);
  assign is_close = cmd_valid && (cmd_op == OP_CLOSE);

  always_comb begin
    pend_d  = pend_q;
    plo_d   = plo_q;
    pmode_d = pmode_q;
    if (is_low && !none_free) begin
      pend_d  = 1'b1;
      plo_d   = cmd_line;
      pmode_d = cmd_mode;
    end else if (is_high && pend_q) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      plo_q   <= '0;
      pmode_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      plo_q   <= plo_d;
      pmode_q <= pmode_d;
    end
  end

  inj_alloc #(.N(ENTRIES)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (vld),
    .grant     (grant),
    .none_free (none_free)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign wr_en[g] = is_high && pend_q && grant[g];

    inj_entry #(.LW(LINE_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[g]),
      .wr_lo    (plo_q),
      .wr_hi    (cmd_line),
      .wr_mode  (pmode_q),
      .clr_en   (is_close),
      .clr_line (cmd_line),
      .snp_kind (snp_kind),
      .snp_line (snp_line),
      .vld      (vld[g]),
      .hit      (hit[g])
    );
  end

  // capture decision, registered one cycle after the snoop
  logic              match, replaceable;
  logic              fire_q, fire_d, drop_q, drop_d;
  logic [LINE_W-1:0] line_q, line_d;

  assign match       = snp_valid && !snp_own && (|hit);
  assign replaceable = (vic_state == VIC_INV) || (vic_state == VIC_SHR);

  always_comb begin
    fire_d = match && replaceable;
    drop_d = match && !replaceable;
    line_d = match ? snp_line : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      drop_q <= 1'b0;
      line_q <= '0;
    end else begin
      fire_q <= fire_d;
      drop_q <= drop_d;
      line_q <= line_d;
    end
  end

  assign inj_fire = fire_q;
  assign inj_drop = drop_q;
  assign inj_line = line_q;
  assign tbl_full = none_free;

  assert_fire_after_snoop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> $past(snp_valid));
  assert_own_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_fire || inj_drop) |-> $past(!snp_own));
  assert_fire_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> ($past(vic_state) == VIC_INV || $past(vic_state) == VIC_SHR));
  assert_drop_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_drop |-> ($past(vic_state) == VIC_MOD || $past(vic_state) == VIC_EXC));
  assert_orphan_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_high && !pend_q) |=> $stable(vld));
  assert_full_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_low && tbl_full) |=> ($stable(vld) && !pend_q));
  assert_fire_drop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_fire && inj_drop));
  assert_fire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_fire && !$past(snp_valid && !snp_own)) |-> 1'b0);
endmodule

// File: tb/inj_window_table_test.sv
module inj_window_table_test;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int NE = 4;
  localparam int LW = AW - $clog2(LB);

  logic          clk, rst_n;
  logic          cmd_valid, cmd_mode;
  logic [1:0]    cmd_op;
  logic [LW-1:0] cmd_line;
  logic          snp_valid, snp_kind, snp_own;
  logic [LW-1:0] snp_line;
  logic [1:0]    vic_state;
  logic          inj_fire, inj_drop, tbl_full;
  logic [LW-1:0] inj_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  inj_window_table #(.ADDR_W(AW), .LINE_BYTES(LB), .ENTRIES(NE)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_line(cmd_line),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_own(snp_own), .snp_line(snp_line),
    .vic_state(vic_state),
    .inj_fire(inj_fire), .inj_drop(inj_drop), .inj_line(inj_line), .tbl_full(tbl_full)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input bit mode, input logic [LW-1:0] line);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_mode = mode; cmd_line = line;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
  endtask

  task automatic open_win(input bit mode, input logic [LW-1:0] lo, input logic [LW-1:0] hi);
    do_cmd(2'b01, mode, lo);
    do_cmd(2'b10, 1'b0, hi);
  endtask

  task automatic snoop(input string req, input bit kind, input bit own,
                       input logic [LW-1:0] line, input logic [1:0] vic,
                       input bit ef, input bit ed);
    @(negedge clk);
    snp_valid = 1; snp_kind = kind; snp_own = own; snp_line = line; vic_state = vic;
    @(posedge clk);
    #1;
    snp_valid = 0;
    chk(req, "inj_fire", inj_fire, ef);
    chk(req, "inj_drop", inj_drop, ed);
    if (ef || ed) chk(req, "inj_line", inj_line, line);
    @(posedge clk);
    #1;
    chk(req, "fire one cycle", inj_fire, 0);
  endtask

  task automatic t_reset;
    chk("R1", "inj_fire", inj_fire, 0);
    chk("R1", "inj_drop", inj_drop, 0);
    chk("R1", "tbl_full", tbl_full, 0);
    snoop("R1", 0, 0, 27'h0, 2'b00, 0, 0);
    snoop("R1", 1, 0, 27'h0, 2'b00, 0, 0);
  endtask

  task automatic t_bounds;
    open_win(0, 27'h80, 27'h87);
    snoop("R2", 0, 0, 27'h80, 2'b00, 1, 0);
    snoop("R2", 0, 0, 27'h87, 2'b01, 1, 0);
    snoop("R2", 0, 0, 27'h84, 2'b00, 1, 0);
    snoop("R2", 0, 0, 27'h7F, 2'b00, 0, 0);
    snoop("R2", 0, 0, 27'h88, 2'b00, 0, 0);
    // R3: line address with all offset bits removed matches directly
    snoop("R3", 0, 0, LW'(32'h1000 >> 5), 2'b00, 1, 0);
  endtask

  task automatic t_mode;
    snoop("R4", 1, 0, 27'h82, 2'b00, 0, 0);
    open_win(1, 27'h100, 27'h101);
    snoop("R4", 1, 0, 27'h101, 2'b00, 1, 0);
    snoop("R4", 0, 0, 27'h101, 2'b00, 0, 0);
  endtask

  task automatic t_own;
    snoop("R5", 0, 1, 27'h82, 2'b00, 0, 0);
    snoop("R5", 1, 1, 27'h100, 2'b10, 0, 0);
  endtask

  task automatic t_victim;
    snoop("R6", 0, 0, 27'h83, 2'b10, 0, 1);
    snoop("R6", 0, 0, 27'h83, 2'b11, 0, 1);
    snoop("R6", 0, 0, 27'h83, 2'b01, 1, 0);
  endtask

  task automatic t_close_orphan;
    do_cmd(2'b11, 0, 27'h80);
    snoop("R9", 0, 0, 27'h82, 2'b00, 0, 0);
    snoop("R9", 1, 0, 27'h100, 2'b00, 1, 0);
    do_cmd(2'b10, 0, 27'h180);
    snoop("R7", 0, 0, 27'h180, 2'b00, 0, 0);
    snoop("R7", 1, 0, 27'h180, 2'b00, 0, 0);
    chk("R7", "tbl_full", tbl_full, 0);
  endtask

  task automatic t_full;
    open_win(0, 27'h200, 27'h200);
    open_win(0, 27'h280, 27'h280);
    chk("R8", "tbl_full early", tbl_full, 0);
    open_win(0, 27'h300, 27'h300);
    chk("R8", "tbl_full", tbl_full, 1);
    open_win(0, 27'h380, 27'h380);
    snoop("R8", 0, 0, 27'h380, 2'b00, 0, 0);
    snoop("R8", 0, 0, 27'h280, 2'b00, 1, 0);
    chk("R8", "tbl_full kept", tbl_full, 1);
    do_cmd(2'b11, 0, 27'h280);
    chk("R9", "tbl_full after close", tbl_full, 0);
    open_win(0, 27'h380, 27'h380);
    snoop("R9", 0, 0, 27'h380, 2'b00, 1, 0);
    snoop("R9", 0, 0, 27'h280, 2'b00, 0, 0);
    chk("R9", "tbl_full reuse", tbl_full, 1);
  endtask

  task automatic t_overlap;
    do_cmd(2'b11, 0, 27'h200);
    open_win(1, 27'h100, 27'h103);
    snoop("R10", 1, 0, 27'h101, 2'b00, 1, 0);
    snoop("R10", 1, 0, 27'h101, 2'b10, 0, 1);
    snoop("R10", 1, 0, 27'h103, 2'b00, 1, 0);
    snoop("R10", 1, 0, 27'h104, 2'b00, 0, 0);
    do_cmd(2'b11, 0, 27'h100);
    snoop("R9", 1, 0, 27'h101, 2'b00, 0, 0);
    snoop("R9", 1, 0, 27'h103, 2'b00, 0, 0);
    chk("R9", "tbl_full two closed", tbl_full, 0);
  endtask

  initial begin
    cmd_valid = 0; cmd_op = 0; cmd_mode = 0; cmd_line = 0;
    snp_valid = 0; snp_kind = 0; snp_own = 0; snp_line = 0; vic_state = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bounds;
    t_mode;
    t_own;
    t_victim;
    t_close_orphan;
    t_full;
    t_overlap;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule